// File: doc/BRIEF.md
# SIMD Divergence Mask Stack

This block keeps the per-lane activity state for a 32-lane SIMD group while it runs divergent if/else code. Every lane runs every instruction. Only the lanes whose bit is set in the current active mask may commit their results. The sequencer sends three kinds of command together with a 32-bit per-lane predicate:

- **Enter** is issued at a divergent branch. It saves the current mask on an internal stack and narrows the mask to the lanes whose predicate is true.
- **Flip** is issued at the else path. It activates the other lanes of the saved group.
- **Leave** is issued at the reconvergence point. It restores the mask that was saved.

After an enter or flip, the block also raises a one-cycle skip indication when the new mask has no active lane. The sequencer can then jump over that path.

The stack holds eight nested levels. An enter at full depth raises a one-cycle overflow error and changes nothing. A flip or leave at zero depth raises a one-cycle underflow error and changes nothing.

Top module: `simd_mask_stack`

## Requirements
- R1: After reset, `active_mask` is all ones, `depth` is 0, and `branch_skip`, `overflow_err` and `underflow_err` are low.
- R2: `cmd` = 2'b01 (enter) with `depth` below 8 saves the current mask on the stack. In the next cycle, `active_mask` equals the old mask AND `pred`, and `depth` has increased by one.
- R3: `cmd` = 2'b10 (flip) with `depth` above 0 sets `active_mask` to the top saved mask AND NOT `pred`. It leaves `depth` and the stack unchanged, so repeated flips always use the same saved mask.
- R4: `cmd` = 2'b11 (leave) with `depth` above 0 restores `active_mask` to the top saved mask and decreases `depth` by one.
- R5: Nesting is last-in first-out for up to 8 levels. Each leave returns exactly the mask that was in force before the matching enter.
- R6: An enter at `depth` 8 raises `overflow_err` for exactly one cycle and leaves the mask, the depth and the stack unchanged.
- R7: A flip or a leave at `depth` 0 raises `underflow_err` for exactly one cycle and leaves the mask and the depth unchanged.
- R8: `branch_skip` is high for exactly the one cycle after a legal enter or flip whose resulting mask is all zero. It is low in every other cycle.
- R9: `cmd` = 2'b00 (hold) leaves the mask and the depth unchanged, and all three flags are low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | 00 hold, 01 enter, 10 flip, 11 leave |
| pred | input | 32 | Per-lane branch predicate |
| active_mask | output | 32 | Lanes allowed to commit |
| depth | output | 4 | Number of saved masks |
| branch_skip | output | 1 | New mask is empty, so the path may be skipped |
| overflow_err | output | 1 | Enter refused because the stack is full |
| underflow_err | output | 1 | Flip or leave refused because the stack is empty |

## Verification
The hardest situation to reach is overflow that has real content underneath it. That needs eight nested enters whose predicates keep lanes alive, followed by a refused ninth enter and then a full unwind in which every restored mask is checked. The directed part of the stimulus builds that ladder with a distinct predicate at each level and then drains it past empty, so that both error paths are hit. A long random command stream, weighted toward enters and leaves, then reaches mixed depths with both sparse and empty masks. A behavioural queue model tracks the expected state and is compared with every output after each clock.

// File: rtl/simd_mask_stack.sv
module simd_mask_stack #(
  parameter int LANES = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cmd,
  input  logic [LANES-1:0] pred,
  output logic [LANES-1:0] active_mask,
  output logic [$clog2(DEPTH+1)-1:0] depth,
  output logic             branch_skip,
  output logic             overflow_err,
  output logic             underflow_err
);
  localparam int DW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [DW-1:0] FULL = DW'(DEPTH);
  localparam logic [1:0] CMD_HOLD = 2'b00, CMD_ENTER = 2'b01,
                         CMD_FLIP = 2'b10, CMD_LEAVE = 2'b11;

  logic [LANES-1:0] stack_q [DEPTH];
  logic [LANES-1:0] mask_q;
  logic [DW-1:0]    depth_q;
  logic             skip_q, ovf_q, udf_q;

  wire              is_full   = (depth_q == FULL);
  wire              is_empty  = (depth_q == '0);
  wire [AW-1:0]     wr_idx    = depth_q[AW-1:0];
  wire [AW-1:0]     top_idx   = wr_idx - 1'b1;
  wire [LANES-1:0]  top_mask  = stack_q[top_idx];
  wire [LANES-1:0]  then_mask = mask_q & pred;
  wire [LANES-1:0]  else_mask = top_mask & ~pred;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '1;
      depth_q <= '0;
      skip_q  <= 1'b0;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) stack_q[i] <= '0;
    end else begin
      skip_q <= 1'b0;
      ovf_q  <= 1'b0;
      udf_q  <= 1'b0;
      case (cmd)
        CMD_ENTER:
          if (is_full) ovf_q <= 1'b1;
          else begin
            stack_q[wr_idx] <= mask_q;
            mask_q  <= then_mask;
            depth_q <= depth_q + 1'b1;
            skip_q  <= (then_mask == '0);
          end
        CMD_FLIP:
          if (is_empty) udf_q <= 1'b1;
          else begin
            mask_q <= else_mask;
            skip_q <= (else_mask == '0);
          end
        CMD_LEAVE:
          if (is_empty) udf_q <= 1'b1;
          else begin
            mask_q  <= top_mask;
            depth_q <= depth_q - 1'b1;
          end
        default: ;
      endcase
    end
  end

  assign active_mask   = mask_q;
  assign depth         = depth_q;
  assign branch_skip   = skip_q;
  assign overflow_err  = ovf_q;
  assign underflow_err = udf_q;

  p_enter_narrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ENTER && !is_full) |=>
      (depth_q == $past(depth_q) + 1'b1) && ((mask_q & ~$past(mask_q)) == '0));

  p_flip_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_FLIP && !is_empty) |=>
      $stable(depth_q) && ((mask_q & $past(pred)) == '0));

  p_leave_depth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LEAVE && !is_empty) |=> depth_q == $past(depth_q) - 1'b1);

  p_depth_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= FULL);

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ENTER && is_full) |=>
      ovf_q && !udf_q && $stable(mask_q) && $stable(depth_q));

  p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_FLIP || cmd == CMD_LEAVE) && is_empty) |=>
      udf_q && !ovf_q && $stable(mask_q) && $stable(depth_q));

  p_skip_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q |-> (mask_q == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_HOLD) |=>
      $stable(mask_q) && $stable(depth_q) && !skip_q && !ovf_q && !udf_q);
endmodule

// File: tb/simd_mask_stack_tb.sv
`timescale 1ns/1ps
module simd_mask_stack_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd = 2'b00;
  logic [31:0] pred = '0;
  logic [31:0] active_mask;
  logic [3:0]  depth;
  logic        branch_skip, overflow_err, underflow_err;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] m_mask = '1;
  logic [31:0] m_stack[$];
  bit m_skip = 0, m_ovf = 0, m_udf = 0;

  always #4 clk = ~clk;

  simd_mask_stack dut_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .pred(pred),
    .active_mask(active_mask), .depth(depth), .branch_skip(branch_skip),
    .overflow_err(overflow_err), .underflow_err(underflow_err));

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "active_mask", active_mask, m_mask);
    chk(tag, "depth", {28'd0, depth}, m_stack.size());
    chk(tag, "branch_skip", {31'd0, branch_skip}, {31'd0, m_skip});
    chk(tag, "overflow_err", {31'd0, overflow_err}, {31'd0, m_ovf});
    chk(tag, "underflow_err", {31'd0, underflow_err}, {31'd0, m_udf});
  endtask

  task automatic model(logic [1:0] c, logic [31:0] p);
    m_skip = 0; m_ovf = 0; m_udf = 0;
    case (c)
      2'b01: if (m_stack.size() == 8) m_ovf = 1;
             else begin
               m_stack.push_back(m_mask);
               m_mask = m_mask & p;
               m_skip = (m_mask == 0);
             end
      2'b10: if (m_stack.size() == 0) m_udf = 1;
             else begin
               m_mask = m_stack[$] & ~p;
               m_skip = (m_mask == 0);
             end
      2'b11: if (m_stack.size() == 0) m_udf = 1;
             else m_mask = m_stack.pop_back();
      default: ;
    endcase
  endtask

  task automatic step(string tag, logic [1:0] c, logic [31:0] p);
    cmd = c; pred = p;
    @(posedge clk);
    model(c, p);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare("R1");
    step("R9", 2'b00, 32'hFFFF_0000);
    step("R7", 2'b11, 32'h0);
    step("R7", 2'b10, 32'h1234_5678);
    step("R2", 2'b01, 32'h0F0F_0F0F);
    step("R3", 2'b10, 32'h0F0F_0F0F);
    step("R3", 2'b10, 32'h0000_FFFF);
    step("R9", 2'b00, 32'h0);
    step("R4", 2'b11, 32'h0);
    step("R8", 2'b01, 32'h0);
    step("R8", 2'b10, 32'h0);
    step("R8", 2'b10, 32'hFFFF_FFFF);
    step("R4", 2'b11, 32'h0);
    for (int i = 0; i < 8; i++)
      step("R5", 2'b01, ~(32'h1 << (i * 3)));
    step("R6", 2'b01, 32'h0);
    step("R6", 2'b00, 32'h0);
    for (int i = 0; i < 8; i++) step("R5", 2'b11, 32'h0);
    step("R7", 2'b11, 32'h0);
    step("R7", 2'b10, 32'h0);
    for (int i = 0; i < 2000; i++) begin
      int r = int'($urandom_range(0, 9));
      logic [1:0] c = (r < 4) ? 2'b01 : (r < 6) ? 2'b10 : (r < 9) ? 2'b11 : 2'b00;
      logic [31:0] p = ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom | $urandom;
      step("R5", c, p);
    end
    rst_n = 1'b0;
    cmd = 2'b01;
    @(posedge clk);
    m_mask = '1; m_stack.delete(); m_skip = 0; m_ovf = 0; m_udf = 0;
    @(negedge clk);
    cmd = 2'b00;
    rst_n = 1'b1;
    compare("R1");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule